// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns one starting column into the sequence of column addresses for a synchronous DRAM burst, one address per clock. The controller above it presents a start column together with a burst-length code and a wrap-order select. From the next clock on, the block issues one beat per cycle until the burst is done, until a stop request arrives, or until a fresh start column replaces the burst in progress.

Fixed bursts of 1, 2, 4 or 8 beats stay inside the aligned block of that size that contains the start column. The order inside that block is either an upward count that wraps at the block edge, or the start's low bits XORed with the beat number. A full-page burst steps through the whole column space, wrapping from the top column back to zero, and runs until it is stopped or restarted. Storage, bank and row tracking and read latency belong to other blocks.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, beatValid and lastBeat are 0 and colOut is 0 until the first start.
- R2: When startValid is high at a clock edge, then after that edge beatValid is 1 and colOut equals startCol. lenSel and wrapSel are sampled at that same edge only, so later changes do not affect the burst in progress.
- R3: lenSel codes 0, 1, 2 and 3 select bursts of 1, 2, 4 and 8 beats. Every code from 4 to 7 selects full page. A fixed burst issues exactly that many beats on consecutive cycles, and beatValid is 0 on the cycle after the last beat unless a new start arrived.
- R4: With wrapSel = 0 (sequential), beat k of a burst of length BL has low log2(BL) bits equal to (start low bits + k) mod BL. The upper bits are those of the start column.
- R5: With wrapSel = 1 (interleaved), beat k of a burst of length BL has low log2(BL) bits equal to the start's low bits XOR k. The upper bits are those of the start column.
- R6: In full page, beat k is (startCol + k) mod 512 for either value of wrapSel. The burst continues until a stop or a new start, and lastBeat stays 0.
- R7: lastBeat is 1 only on the final beat of a fixed burst. A burst of length 1 gives a single beat, and that beat has lastBeat set.
- R8: A start during a burst abandons it and begins a new burst at the new column on the next cycle. A start has priority over a stop presented in the same cycle.
- R9: A stop without a start drops beatValid on the next cycle. The block then stays idle until a new start. A stop while idle has no effect.
- R10: lastBeat is never 1 while beatValid is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| startValid | input | 1 | Begin a new burst at startCol |
| startCol | input | 9 | Starting column of the new burst |
| lenSel | input | 3 | Burst length code (0..3 fixed, 4..7 full page) |
| wrapSel | input | 1 | Wrap order: 0 sequential, 1 interleaved |
| stopReq | input | 1 | End the current burst early |
| colOut | output | 9 | Column address of the current beat |
| beatValid | output | 1 | colOut is a valid beat |
| lastBeat | output | 1 | Current beat is the final beat of a fixed burst |

## Verification
The bound checker watches several rules on every cycle. It checks that a start loads its column on the next cycle, that a stop or a final beat without a new start leaves the block idle, that an idle block stays idle without a start, and that lastBeat only occurs with beatValid. It also checks that a full-page burst advances by exactly one column per cycle with no final flag. The exact sequential and interleaved address orders for each burst length, the sampling of length and wrap settings only at the start edge, the wrap from column 511 to 0, and the replacement of a burst part way through can only be shown by the bench's directed scenarios, which compare every beat with addresses computed from the requirements.

// File: rtl/burst_col_gen_pkg.sv
package burst_col_gen_pkg;

  // Strobes from the sequencing control to the address datapath.
  typedef struct packed {
    logic load;   // new burst accepted this cycle
    logic step;   // advance to the next beat
    logic halt;   // burst ended by stop request
  } ctrlStrobes_t;

endpackage

// File: rtl/burst_col_ctrl.sv
module burst_col_ctrl
  import burst_col_gen_pkg::*;
#(
  parameter int COL_W   = 9,
  parameter int LEN_W   = 3,
  parameter int MAX_LOG = 3,
  localparam int LOG_W  = $clog2(MAX_LOG + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startValid,
  input  logic               stopReq,
  input  logic [LEN_W-1:0]   lenSel,
  output ctrlStrobes_t       strobes,
  output logic [COL_W-1:0]   beatIdx,
  output logic               fullPage,
  output logic [LOG_W-1:0]   lenLog,
  output logic               beatValid,
  output logic               lastBeat
);

  logic             activeQ;
  logic [COL_W-1:0] beatQ;
  logic             fullQ;
  logic [LOG_W-1:0] logQ;

  logic             decFull;
  logic [LOG_W-1:0] decLog;
  logic [COL_W-1:0] lastIdx;
  logic             finalBeat;

  // Length code decode: codes above the largest fixed length mean full page.
  always_comb begin
    decFull = (lenSel > LEN_W'(MAX_LOG));
    decLog  = decFull ? LOG_W'(MAX_LOG) : lenSel[LOG_W-1:0];
  end

  always_comb begin
    lastIdx   = (COL_W'(1) << logQ) - COL_W'(1);
    finalBeat = activeQ && !fullQ && (beatQ == lastIdx);
  end

  always_comb begin
    strobes.load = startValid;
    strobes.halt = !startValid && stopReq;
    strobes.step = !startValid && !stopReq && activeQ && !finalBeat;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      beatQ   <= '0;
      fullQ   <= 1'b0;
      logQ    <= '0;
    end else if (strobes.load) begin
      activeQ <= 1'b1;
      beatQ   <= '0;
      fullQ   <= decFull;
      logQ    <= decLog;
    end else if (strobes.halt) begin
      activeQ <= 1'b0;
    end else if (strobes.step) begin
      beatQ   <= beatQ + COL_W'(1);
    end else begin
      activeQ <= 1'b0;
    end
  end

  assign beatIdx   = beatQ;
  assign fullPage  = fullQ;
  assign lenLog    = logQ;
  assign beatValid = activeQ;
  assign lastBeat  = finalBeat;

endmodule

// File: rtl/burst_col_addr.sv
module burst_col_addr
  import burst_col_gen_pkg::*;
#(
  parameter int COL_W   = 9,
  parameter int MAX_LOG = 3,
  localparam int LOG_W  = $clog2(MAX_LOG + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [COL_W-1:0]   startCol,
  input  logic               wrapSel,
  input  logic [COL_W-1:0]   beatIdx,
  input  logic               fullPage,
  input  logic [LOG_W-1:0]   lenLog,
  output logic [COL_W-1:0]   colOut
);

  logic [COL_W-1:0] baseQ;
  logic             interQ;
  logic [COL_W-1:0] seqSum;
  logic [COL_W-1:0] xorVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ  <= '0;
      interQ <= 1'b0;
    end else if (strobes.load) begin
      baseQ  <= startCol;
      interQ <= wrapSel;
    end
  end

  // Carries out of the burst block never reach the low bits, so the low
  // bits of the plain sum give the in-block sequential wrap.
  assign seqSum = baseQ + beatIdx;
  assign xorVal = baseQ ^ beatIdx;

  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    if (i < MAX_LOG) begin : g_low
      localparam logic [LOG_W:0] BITPOS = (LOG_W + 1)'(i);
      logic inBlock;
      assign inBlock = ({1'b0, lenLog} > BITPOS);
      always_comb begin
        if (fullPage)
          colOut[i] = seqSum[i];
        else if (!inBlock)
          colOut[i] = baseQ[i];
        else if (interQ)
          colOut[i] = xorVal[i];
        else
          colOut[i] = seqSum[i];
      end
    end else begin : g_high
      assign colOut[i] = fullPage ? seqSum[i] : baseQ[i];
    end
  end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_gen_pkg::*;
#(
  parameter int COL_W   = 9,
  parameter int LEN_W   = 3,
  parameter int MAX_LOG = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startValid,
  input  logic [COL_W-1:0] startCol,
  input  logic [LEN_W-1:0] lenSel,
  input  logic             wrapSel,
  input  logic             stopReq,
  output logic [COL_W-1:0] colOut,
  output logic             beatValid,
  output logic             lastBeat
);

  localparam int LOG_W = $clog2(MAX_LOG + 1);

  ctrlStrobes_t     strobes;
  logic [COL_W-1:0] beatIdx;
  logic             fullPage;
  logic [LOG_W-1:0] lenLog;

  burst_col_ctrl #(
    .COL_W  (COL_W),
    .LEN_W  (LEN_W),
    .MAX_LOG(MAX_LOG)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startValid(startValid),
    .stopReq   (stopReq),
    .lenSel    (lenSel),
    .strobes   (strobes),
    .beatIdx   (beatIdx),
    .fullPage  (fullPage),
    .lenLog    (lenLog),
    .beatValid (beatValid),
    .lastBeat  (lastBeat)
  );

  burst_col_addr #(
    .COL_W  (COL_W),
    .MAX_LOG(MAX_LOG)
  ) u_addr (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .startCol(startCol),
    .wrapSel (wrapSel),
    .beatIdx (beatIdx),
    .fullPage(fullPage),
    .lenLog  (lenLog),
    .colOut  (colOut)
  );

endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
  parameter int COL_W   = 9,
  parameter int LEN_W   = 3,
  parameter int MAX_LOG = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             startValid,
  input logic [COL_W-1:0] startCol,
  input logic [LEN_W-1:0] lenSel,
  input logic             stopReq,
  input logic [COL_W-1:0] colOut,
  input logic             beatValid,
  input logic             lastBeat
);

  // Checker's own record of whether the running burst is full page.
  logic fullTrk;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           fullTrk <= 1'b0;
    else if (startValid) fullTrk <= (lenSel > LEN_W'(MAX_LOG));
  end

  p_start_loads_r2: assert property (@(posedge clk) disable iff (!rstN)
    startValid |=> (beatValid && colOut == $past(startCol)));

  p_fixed_runs_on_r3: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && !lastBeat && !startValid && !stopReq) |=> beatValid);

  p_full_steps_r6: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && fullTrk && !startValid && !stopReq)
      |=> (beatValid && !lastBeat && colOut == COL_W'($past(colOut) + COL_W'(1))));

  p_end_after_last_r7: assert property (@(posedge clk) disable iff (!rstN)
    (lastBeat && !startValid) |=> !beatValid);

  p_stop_idles_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stopReq && !startValid) |=> !beatValid);

  p_idle_holds_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!beatValid && !startValid) |=> !beatValid);

  p_last_valid_r10: assert property (@(posedge clk) disable iff (!rstN)
    lastBeat |-> beatValid);

endmodule

bind burst_col_gen burst_col_gen_chk #(
  .COL_W  (COL_W),
  .LEN_W  (LEN_W),
  .MAX_LOG(MAX_LOG)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .startValid(startValid),
  .startCol  (startCol),
  .lenSel    (lenSel),
  .stopReq   (stopReq),
  .colOut    (colOut),
  .beatValid (beatValid),
  .lastBeat  (lastBeat)
);

// File: tb/burst_col_gen_test.sv
module burst_col_gen_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startValid = 1'b0;
  logic [8:0] startCol = '0;
  logic [2:0] lenSel = '0;
  logic       wrapSel = 1'b0;
  logic       stopReq = 1'b0;
  logic [8:0] colOut;
  logic       beatValid;
  logic       lastBeat;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  burst_col_gen uut (
    .clk       (clk),
    .rstN      (rstN),
    .startValid(startValid),
    .startCol  (startCol),
    .lenSel    (lenSel),
    .wrapSel   (wrapSel),
    .stopReq   (stopReq),
    .colOut    (colOut),
    .beatValid (beatValid),
    .lastBeat  (lastBeat)
  );

  task automatic chk(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Expected column of beat k, worked out from the requirements.
  function automatic int expCol(int start, int code, bit inter, int k);
    int bl, base, low;
    if (code >= 4) return (start + k) % 512;
    bl   = 1 << code;
    low  = start % bl;
    base = start - low;
    if (inter) return base + (low ^ k);
    return base + ((low + k) % bl);
  endfunction

  // Present a start for one cycle; on return beat 0 is on the outputs.
  task automatic startBurst(int col, int code, bit inter, bit withStop);
    @(negedge clk);
    startValid = 1'b1;
    startCol   = 9'(col);
    lenSel     = 3'(code);
    wrapSel    = inter;
    stopReq    = withStop;
    @(negedge clk);
    startValid = 1'b0;
    stopReq    = 1'b0;
  endtask

  // Check beats 0..n-1 of the current burst, one per cycle.
  task automatic checkBeats(string req, int col, int code, bit inter, int n, bit lastOnEnd);
    for (int k = 0; k < n; k++) begin
      chk(req, "beatValid", int'(beatValid), 1);
      chk(req, "colOut", int'(colOut), expCol(col, code, inter, k));
      chk("R7", "lastBeat", int'(lastBeat), (lastOnEnd && k == n - 1) ? 1 : 0);
      if (k != n - 1) @(negedge clk);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "beatValid", int'(beatValid), 0);
    chk("R1", "lastBeat", int'(lastBeat), 0);
    chk("R1", "colOut", int'(colOut), 0);
  endtask

  task automatic t_fixed(string req, int col, int code, bit inter);
    startBurst(col, code, inter, 1'b0);
    checkBeats(req, col, code, inter, 1 << code, 1'b1);
    @(negedge clk);
    chk("R3", "beatValid after burst", int'(beatValid), 0);
  endtask

  task automatic t_latch();
    startBurst(45, 2, 1'b0, 1'b0);
    lenSel  = 3'd7;
    wrapSel = 1'b1;
    checkBeats("R2", 45, 2, 1'b0, 4, 1'b1);
    @(negedge clk);
    chk("R2", "beatValid after burst", int'(beatValid), 0);
  endtask

  task automatic t_fullPage();
    startBurst(509, 7, 1'b1, 1'b0);
    checkBeats("R6", 509, 7, 1'b0, 6, 1'b0);
    stopReq = 1'b1;
    @(negedge clk);
    stopReq = 1'b0;
    chk("R9", "beatValid after stop", int'(beatValid), 0);
    repeat (3) @(negedge clk);
    chk("R9", "beatValid idle", int'(beatValid), 0);
    chk("R10", "lastBeat idle", int'(lastBeat), 0);
  endtask

  task automatic t_interrupt();
    startBurst(5, 3, 1'b0, 1'b0);
    checkBeats("R8", 5, 3, 1'b0, 3, 1'b0);
    startBurst(102, 1, 1'b1, 1'b0);
    checkBeats("R8", 102, 1, 1'b1, 2, 1'b1);
    @(negedge clk);
    chk("R8", "beatValid after new burst", int'(beatValid), 0);
    // start and stop together: start wins
    startBurst(300, 2, 1'b1, 1'b1);
    checkBeats("R8", 300, 2, 1'b1, 4, 1'b1);
    @(negedge clk);
  endtask

  task automatic t_stopIdle();
    stopReq = 1'b1;
    @(negedge clk);
    stopReq = 1'b0;
    chk("R9", "stop while idle", int'(beatValid), 0);
    startBurst(200, 5, 1'b0, 1'b0);
    checkBeats("R3", 200, 5, 1'b0, 3, 1'b0);
    stopReq = 1'b1;
    @(negedge clk);
    stopReq = 1'b0;
    chk("R9", "stop mid burst", int'(beatValid), 0);
  endtask

  initial begin
    t_reset();
    t_fixed("R7", 77, 0, 1'b0);
    t_fixed("R4", 6, 1, 1'b0);
    t_fixed("R4", 131, 2, 1'b0);
    t_fixed("R4", 254, 3, 1'b0);
    t_fixed("R5", 131, 2, 1'b1);
    t_fixed("R5", 381, 3, 1'b1);
    t_fixed("R5", 3, 1, 1'b1);
    t_latch();
    t_fullPage();
    t_interrupt();
    t_stopIdle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule